// File: doc/BRIEF.md
# Flash Controller Interrupt Aggregator

This block gathers the event signals of a flash memory controller into one interrupt line. Six event inputs each set a sticky status bit: device ready, controller ready, decode failure, decode error, ECC ready and write-protect fault. A mask register selects which sticky bits may raise the interrupt. Software reads the sticky register with a one-cycle read strobe. The value returned is the set of bits held at the strobe, and the read clears exactly those bits.

Beside the sticky view, the block keeps a registered live-status word. It reports the current level conditions of the controller. It packs a corrected-symbol count field next to the ready flags and the error flags. It also drives a combined ready flag, which is true only when both the controller and the flash device report ready.

Top module: `flash_irq_unit`

## Requirements
- R1: Each event input bit sets its sticky bit on the next clock edge, and the bit stays set until a status read. Bit positions are: 5 device ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault. The same positions apply to the mask.
- R2: A cycle with `stat_rd` high loads `stat_rdata` with the sticky bits held at that edge, and clears them. The value is visible from the following cycle.
- R3: An event arriving in the same cycle as a status read is not returned by that read. It stays set and is returned by the next read.
- R4: `irq_o` is active-high and level-sensitive. It is high exactly while some sticky bit and its mask bit are both 1. It changes on the same edge as the sticky bits and the mask.
- R5: The mask resets to all zeros. A masked event still sets its sticky bit, so polling can see it, and the bit raises `irq_o` once it is unmasked.
- R6: The `live_o` layout is: bit 6 decoder failure, bits [5:4] error count, bit 3 errors detected, bit 2 ECC ready, bit 1 controller ready, bit 0 device ready. It is registered, so it shows the inputs one cycle later.
- R7: Bit 3 of `live_o` is high when `lv_corr` is non-zero. Bits [5:4] then hold the count minus one, so 0 to 3 mean 1 to 4 corrections. Counts above 4 saturate to 3. A count of zero gives field 0.
- R8: `both_rdy_o` is 1 only when the controller-ready and device-ready live inputs are both 1. It has the same one-cycle latency as `live_o`.
- R9: A synchronous reset clears the sticky bits, the mask, the read data, the live word, `both_rdy_o` and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 6 | Event pulses or levels, one per sticky bit |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 6 | New mask value |
| stat_rd | input | 1 | Sticky status read strobe (clear on read) |
| stat_rdata | output | 6 | Sticky bits captured by the last read |
| irq_o | output | 1 | Level interrupt, active high |
| lv_dec_fail | input | 1 | Live decoder failure condition |
| lv_corr | input | 3 | Live number of corrected symbols |
| lv_ecc_rdy | input | 1 | Live ECC ready condition |
| lv_ctl_rdy | input | 1 | Live controller ready condition |
| lv_nand_rdy | input | 1 | Live flash device ready condition |
| live_o | output | 7 | Packed live status word |
| both_rdy_o | output | 1 | Controller and device both ready |

## Verification
Faults in the sticky or mask state show at the ports within one cycle. A bit that is lost or stuck shows first as a wrong `irq_o` level, and then as a wrong value on the next read. The read-versus-event collision is the subtle case: a wrong clear term loses the colliding bit. That loss is only visible on the second read, so the bench reads twice. The count encoding is tested at zero, at one, at the maximum of four and above the maximum.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int EV_WP_FAULT = 0;
  localparam int EV_ECC_RDY  = 1;
  localparam int EV_DEC_ERR  = 2;
  localparam int EV_DEC_FAIL = 3;
  localparam int EV_CTL_RDY  = 4;
  localparam int EV_NAND_RDY = 5;
  localparam int NUM_EVENTS  = 6;

  localparam int LV_NAND_RDY = 0;
  localparam int LV_CTL_RDY  = 1;
  localparam int LV_ECC_RDY  = 2;
  localparam int LV_ERR_DET  = 3;
  localparam int LV_CNT_LSB  = 4;
endpackage

// File: rtl/flash_irq_sticky.sv
module flash_irq_sticky #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         rd,
  output logic [N-1:0] sticky_q,
  output logic [N-1:0] sticky_d,
  output logic [N-1:0] rdata_q
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    // read clears only what it returns; a colliding event re-sets the bit
    assign sticky_d[b] = (sticky_q[b] & ~rd) | evt[b];

    always_ff @(posedge clk) begin
      if (rst) begin
        sticky_q[b] <= 1'b0;
        rdata_q[b]  <= 1'b0;
      end else begin
        sticky_q[b] <= sticky_d[b];
        if (rd) rdata_q[b] <= sticky_q[b];
      end
    end
  end
endmodule

// File: rtl/flash_irq_live.sv
module flash_irq_live #(
  parameter int CNT_W  = 2,
  parameter int CORR_W = 3,
  localparam int LIVE_W = CNT_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_fail,
  input  logic [CORR_W-1:0] corr,
  input  logic              ecc_rdy,
  input  logic              ctl_rdy,
  input  logic              nand_rdy,
  output logic [LIVE_W-1:0] live_q,
  output logic              both_q
);
  import flash_irq_pkg::*;

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0]  cnt_enc;
  logic [LIVE_W-1:0] live_d;
  logic [CORR_W:0]   corr_m1;

  always_comb begin
    corr_m1 = {1'b0, corr} - {{CORR_W{1'b0}}, 1'b1};
    if (corr == '0)
      cnt_enc = '0;
    else if (corr_m1 > (CORR_W+1)'(CNT_MAX))
      cnt_enc = CNT_W'(CNT_MAX);
    else
      cnt_enc = corr_m1[CNT_W-1:0];
  end

  always_comb begin
    live_d = '0;
    live_d[LV_NAND_RDY] = nand_rdy;
    live_d[LV_CTL_RDY]  = ctl_rdy;
    live_d[LV_ECC_RDY]  = ecc_rdy;
    live_d[LV_ERR_DET]  = (corr != '0);
    live_d[LV_CNT_LSB +: CNT_W] = cnt_enc;
    live_d[LIVE_W-1]    = dec_fail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      both_q <= 1'b0;
    end else begin
      live_q <= live_d;
      both_q <= ctl_rdy & nand_rdy;
    end
  end
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit #(
  parameter int N_EVT  = 6,
  parameter int CNT_W  = 2,
  parameter int CORR_W = 3,
  localparam int LIVE_W = CNT_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              mask_we,
  input  logic [N_EVT-1:0]  mask_wdata,
  input  logic              stat_rd,
  output logic [N_EVT-1:0]  stat_rdata,
  output logic              irq_o,
  input  logic              lv_dec_fail,
  input  logic [CORR_W-1:0] lv_corr,
  input  logic              lv_ecc_rdy,
  input  logic              lv_ctl_rdy,
  input  logic              lv_nand_rdy,
  output logic [LIVE_W-1:0] live_o,
  output logic              both_rdy_o
);
  logic [N_EVT-1:0] sticky_q, sticky_d;
  logic [N_EVT-1:0] mask_q, mask_d;
  logic             irq_q;

  flash_irq_sticky #(.N(N_EVT)) i_sticky (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_i),
    .rd       (stat_rd),
    .sticky_q (sticky_q),
    .sticky_d (sticky_d),
    .rdata_q  (stat_rdata)
  );

  flash_irq_live #(.CNT_W(CNT_W), .CORR_W(CORR_W)) i_live (
    .clk      (clk),
    .rst      (rst),
    .dec_fail (lv_dec_fail),
    .corr     (lv_corr),
    .ecc_rdy  (lv_ecc_rdy),
    .ctl_rdy  (lv_ctl_rdy),
    .nand_rdy (lv_nand_rdy),
    .live_q   (live_o),
    .both_q   (both_rdy_o)
  );

  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(sticky_d & mask_d);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/flash_irq_chk.sv
module flash_irq_chk #(
  parameter int N_EVT  = 6,
  parameter int LIVE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [N_EVT-1:0]  evt_i,
  input logic              mask_we,
  input logic              stat_rd,
  input logic              irq_o,
  input logic [LIVE_W-1:0] live_o,
  input logic              both_rdy_o,
  input logic [N_EVT-1:0]  sticky_q,
  input logic [N_EVT-1:0]  mask_q
);
  // R1: without a read or a mask change, a raised interrupt stays raised
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !stat_rd && !mask_we) |=> irq_o);

  // R2: a read with no incoming event leaves nothing to interrupt on
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && evt_i == '0 && !mask_we) |=> !irq_o);

  // R3: an unmasked event colliding with a read survives it
  p_collide_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !mask_we && (evt_i & mask_q) != '0) |=> irq_o);

  // R4: the interrupt register agrees with the sticky and mask registers
  p_level_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((sticky_q & mask_q) != '0));

  // R7: with no errors flagged, the count field is zero
  p_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    !live_o[3] |-> live_o[5:4] == 2'b00);

  // R8: the combined ready flag matches the two live ready bits
  p_both_r8: assert property (@(posedge clk) disable iff (rst)
    both_rdy_o == (live_o[1] & live_o[0]));

  // R9: the first cycle after reset has the line low
  p_rst_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !irq_o);
endmodule

bind flash_irq_unit flash_irq_chk #(.N_EVT(N_EVT), .LIVE_W(LIVE_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .mask_we    (mask_we),
  .stat_rd    (stat_rd),
  .irq_o      (irq_o),
  .live_o     (live_o),
  .both_rdy_o (both_rdy_o),
  .sticky_q   (sticky_q),
  .mask_q     (mask_q)
);

// File: tb/test_flash_irq_unit.sv
module test_flash_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] evt_i, mask_wdata;
  logic       mask_we, stat_rd;
  logic [5:0] stat_rdata;
  logic       irq_o;
  logic       lv_dec_fail, lv_ecc_rdy, lv_ctl_rdy, lv_nand_rdy;
  logic [2:0] lv_corr;
  logic [6:0] live_o;
  logic       both_rdy_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_irq_unit i_flash_irq_unit (
    .clk(clk), .rst(rst), .evt_i(evt_i), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .irq_o(irq_o), .lv_dec_fail(lv_dec_fail), .lv_corr(lv_corr),
    .lv_ecc_rdy(lv_ecc_rdy), .lv_ctl_rdy(lv_ctl_rdy),
    .lv_nand_rdy(lv_nand_rdy), .live_o(live_o), .both_rdy_o(both_rdy_o)
  );

  // {mask, event, expected read data, expected irq}
  localparam logic [18:0] VEC [NV] = '{
    {6'h3F, 6'h01, 6'h01, 1'b1},
    {6'h3F, 6'h20, 6'h20, 1'b1},
    {6'h0F, 6'h30, 6'h30, 1'b0},
    {6'h10, 6'h14, 6'h14, 1'b1},
    {6'h2A, 6'h15, 6'h15, 1'b0},
    {6'h01, 6'h3F, 6'h3F, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_read;
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; evt_i = '0; mask_we = 0; mask_wdata = '0; stat_rd = 0;
    lv_dec_fail = 0; lv_corr = '0; lv_ecc_rdy = 0; lv_ctl_rdy = 0; lv_nand_rdy = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R9 irq", irq_o, 0);
    chk("R9 rdata", stat_rdata, 0);
    chk("R9 live", live_o, 0);
    chk("R9 both", both_rdy_o, 0);

    // R5: mask is zero after reset; event is latched but silent
    evt_i = 6'h08; tick(); evt_i = '0;
    chk("R5 masked irq", irq_o, 0);
    mask_we = 1; mask_wdata = 6'h08; tick(); mask_we = 0;
    chk("R5 unmask raises irq", irq_o, 1);
    tick();
    chk("R1 held", irq_o, 1);
    do_read();
    chk("R5 polled value", stat_rdata, 6'h08);
    chk("R2 cleared", irq_o, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      mask_we = 1; mask_wdata = VEC[i][18:13]; tick(); mask_we = 0;
      evt_i = VEC[i][12:7]; tick(); evt_i = '0;
      chk("R4 irq level", irq_o, VEC[i][0]);
      tick();
      chk("R1 sticky hold", irq_o, VEC[i][0]);
      do_read();
      chk("R2 read data", stat_rdata, VEC[i][6:1]);
      chk("R2 irq after read", irq_o, 0);
    end

    // R3: event in the read cycle survives
    mask_we = 1; mask_wdata = 6'h3F; tick(); mask_we = 0;
    evt_i = 6'h01; tick();
    evt_i = 6'h20; stat_rd = 1; tick();
    evt_i = '0; stat_rd = 0;
    chk("R3 first read", stat_rdata, 6'h01);
    chk("R3 irq stays", irq_o, 1);
    do_read();
    chk("R3 second read", stat_rdata, 6'h20);
    do_read();
    chk("R2 empty read", stat_rdata, 6'h00);

    // live status
    lv_corr = 3'd3; lv_ecc_rdy = 1; lv_ctl_rdy = 1; lv_nand_rdy = 0; lv_dec_fail = 0;
    tick();
    chk("R6 R7 live corr3", live_o, 7'h2E);
    chk("R8 one ready", both_rdy_o, 0);
    lv_corr = 3'd4; lv_dec_fail = 1; lv_ecc_rdy = 0; lv_nand_rdy = 1;
    tick();
    chk("R6 R7 live corr4", live_o, 7'h7B);
    chk("R8 both ready", both_rdy_o, 1);
    lv_corr = 3'd0; lv_dec_fail = 0; lv_ctl_rdy = 0; lv_nand_rdy = 0;
    tick();
    chk("R7 zero count", live_o, 7'h00);
    lv_corr = 3'd7; tick();
    chk("R7 saturate", live_o, 7'h38);
    lv_corr = 3'd1; lv_nand_rdy = 1; tick();
    chk("R7 one corr", live_o, 7'h09);
    chk("R8 nand only", both_rdy_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule